// File: doc/BRIEF.md
# Processor Presence Map with Hotplug Event

This block records which processors exist, one bit per processor number, in a flat register of `NUM_IDS` bits (256 by default). Firmware reads the record through a small register window of `NUM_IDS/8` bytes. Only single-byte reads return map contents, and writes to the window change nothing. The hardware side of the chip announces arrivals and departures with single-cycle plug and unplug strobes. Each strobe carries a processor number.

Every accepted strobe updates the matching bit. It also produces a one-cycle pulse on a general-purpose-event set vector, in bit position `GPE_BIT` (2 by default). The event logic uses that pulse to set its status bit and then re-evaluate its interrupt line. While reset is held, the map is loaded from a vector that lists the processors present at power-up. The request number ports are one bit wider than the map index, so numbers past the end of the map can reach the block, and the block discards them.

Top module: `cpu_presence_map`

## Requirements
- R1: While `rst_n` is low at a clock edge, the map takes the value of `init_present`. In the cycle after reset, `rd_vld` is 0 and `gpe_sts_set` is all zeros.
- R2: Window byte `k`, bit `j` (LSB = bit 0) holds the presence bit of processor `8*k + j`.
- R3: A plug strobe with an in-range number sets that processor's bit from the next cycle on. An unplug strobe clears it.
- R4: A plug strobe and an unplug strobe may arrive in the same cycle. With the same number, the bit ends up set. With different numbers, both updates take effect.
- R5: Each cycle that has at least one in-range strobe is followed by exactly one cycle in which `gpe_sts_set` has only bit `GPE_BIT` set. `gpe_sts_set` is all zeros in every other cycle.
- R6: A strobe whose number is `NUM_IDS` or more (256..511 by default) changes no bit and raises no event.
- R7: A read (`win_req`=1, `win_we`=0, `win_byte`=1) returns the addressed byte on `rd_data` with `rd_vld`=1 in the next cycle. A strobe in the same cycle as the read is not yet visible in that byte.
- R8: A window write (`win_req`=1, `win_we`=1) leaves every map bit unchanged and produces no `rd_vld`.
- R9: A read with `win_byte`=0 (a wider access) produces `rd_vld`=1 with `rd_data`=0x00.
- R10: `rd_data` is 0x00 in every cycle in which `rd_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; loads the map |
| init_present | input | NUM_IDS | Processors present at power-up |
| plug_vld | input | 1 | Plug strobe, one cycle |
| plug_id | input | ID_W | Processor number for the plug strobe |
| unplug_vld | input | 1 | Unplug strobe, one cycle |
| unplug_id | input | ID_W | Processor number for the unplug strobe |
| win_req | input | 1 | Window access request |
| win_we | input | 1 | 1 = write (ignored), 0 = read |
| win_byte | input | 1 | 1 = single-byte access |
| win_addr | input | WIN_AW | Byte offset in the window |
| rd_vld | output | 1 | Read data valid |
| rd_data | output | 8 | Read data byte |
| gpe_sts_set | output | GPE_W | One-cycle set pulse for the event status register |

## Verification
The bench drives the following corner cases:
- A tie between plug and unplug on the same number. A block that gives unplug priority would read back a cleared bit.
- Numbers 256 and 259. A block that truncated these to 0 and 3 would corrupt those low bits and also fire an event.
- A read issued in the same cycle as an update. It must return the older byte; a bypass path would leak the new one.
- A series of window writes of every kind, followed by a full sweep of the map, to show that none of them landed.
- Wide reads must return zero.
- A long random mix, checked against a behavioural model on every cycle. It catches any wrong byte/bit ordering or any missing or duplicated event pulse.

// File: rtl/cpm_pkg.sv
package cpm_pkg;

    // Registered read-port state.
    typedef struct packed {
        logic       vld;
        logic [7:0] dat;
    } cpm_rd_t;

    // Registered event state.
    typedef struct packed {
        logic evt;
    } cpm_evt_t;

endpackage

// File: rtl/cpm_req_dec.sv
// Range check and one-hot decode of a processor number.
module cpm_req_dec #(
    parameter int NUM_IDS = 256,
    parameter int ID_W    = 9,
    localparam int IDX_W  = $clog2(NUM_IDS)
) (
    input  logic               vld,
    input  logic [ID_W-1:0]    id,
    output logic               ok,
    output logic [IDX_W-1:0]   idx,
    output logic [NUM_IDS-1:0] mask
);
    always_comb begin
        ok  = vld && ({1'b0, id} < (ID_W+1)'(NUM_IDS));
        idx = id[IDX_W-1:0];
    end

    for (genvar i = 0; i < NUM_IDS; i++) begin : g_bit
        assign mask[i] = ok && (idx == IDX_W'(i));
    end
endmodule

// File: rtl/cpm_bits.sv
// Presence bit storage; set wins over clear.
module cpm_bits #(
    parameter int NUM_IDS = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IDS-1:0] init_bits,
    input  logic [NUM_IDS-1:0] set_mask,
    input  logic [NUM_IDS-1:0] clr_mask,
    output logic [NUM_IDS-1:0] bits_q
);
    logic [NUM_IDS-1:0] bits_d;

    always_comb begin
        if (!rst_n) begin
            bits_d = init_bits;
        end else begin
            bits_d = (bits_q & ~clr_mask) | set_mask;
        end
    end

    always_ff @(posedge clk) begin
        bits_q <= bits_d;
    end

    // R6 / R8: no decoded update means no change to any bit
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask == '0 && clr_mask == '0) |=> $stable(bits_q));
endmodule

// File: rtl/cpm_rd_port.sv
// Byte-wide read window over the presence bits.
module cpm_rd_port
    import cpm_pkg::*;
#(
    parameter int NUM_IDS = 256,
    localparam int BYTES  = NUM_IDS / 8,
    localparam int WIN_AW = $clog2(BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IDS-1:0] bits,
    input  logic               win_req,
    input  logic               win_we,
    input  logic               win_byte,
    input  logic [WIN_AW-1:0]  win_addr,
    output logic               rd_vld,
    output logic [7:0]         rd_data
);
    logic [7:0] byte_arr [BYTES];
    cpm_rd_t    rd_d, rd_q;

    for (genvar g = 0; g < BYTES; g++) begin : g_byte
        assign byte_arr[g] = bits[8*g +: 8];
    end

    always_comb begin
        rd_d.vld = win_req && !win_we;
        rd_d.dat = 8'h00;
        if (win_req && !win_we && win_byte) begin
            rd_d.dat = byte_arr[win_addr];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_vld  = rd_q.vld;
    assign rd_data = rd_q.dat;

    assert_write_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (win_req && win_we) |=> !rd_vld);

    assert_wide_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (win_req && !win_we && !win_byte) |=> (rd_vld && rd_data == 8'h00));

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_vld |-> rd_data == 8'h00);
endmodule

// File: rtl/cpu_presence_map.sv
// Processor presence map with hotplug event pulse.
module cpu_presence_map
    import cpm_pkg::*;
#(
    parameter int NUM_IDS  = 256,
    parameter int ID_W     = 9,
    parameter int GPE_W    = 8,
    parameter int GPE_BIT  = 2,
    localparam int WIN_AW  = $clog2(NUM_IDS / 8)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IDS-1:0] init_present,
    input  logic               plug_vld,
    input  logic [ID_W-1:0]    plug_id,
    input  logic               unplug_vld,
    input  logic [ID_W-1:0]    unplug_id,
    input  logic               win_req,
    input  logic               win_we,
    input  logic               win_byte,
    input  logic [WIN_AW-1:0]  win_addr,
    output logic               rd_vld,
    output logic [7:0]         rd_data,
    output logic [GPE_W-1:0]   gpe_sts_set
);
    localparam int IDX_W = $clog2(NUM_IDS);

    logic               plug_ok, unplug_ok;
    logic [IDX_W-1:0]   plug_idx, unplug_idx;
    logic [NUM_IDS-1:0] set_mask, clr_mask, map_bits;
    cpm_evt_t           ev_d, ev_q;

    cpm_req_dec #(.NUM_IDS(NUM_IDS), .ID_W(ID_W)) u_plug_dec (
        .vld(plug_vld), .id(plug_id), .ok(plug_ok), .idx(plug_idx), .mask(set_mask)
    );

    cpm_req_dec #(.NUM_IDS(NUM_IDS), .ID_W(ID_W)) u_unplug_dec (
        .vld(unplug_vld), .id(unplug_id), .ok(unplug_ok), .idx(unplug_idx), .mask(clr_mask)
    );

    cpm_bits #(.NUM_IDS(NUM_IDS)) u_bits (
        .clk(clk), .rst_n(rst_n), .init_bits(init_present),
        .set_mask(set_mask), .clr_mask(clr_mask), .bits_q(map_bits)
    );

    cpm_rd_port #(.NUM_IDS(NUM_IDS)) u_rd (
        .clk(clk), .rst_n(rst_n), .bits(map_bits),
        .win_req(win_req), .win_we(win_we), .win_byte(win_byte), .win_addr(win_addr),
        .rd_vld(rd_vld), .rd_data(rd_data)
    );

    always_comb begin
        ev_d.evt = plug_ok || unplug_ok;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_q <= '0;
        end else begin
            ev_q <= ev_d;
        end
    end

    assign gpe_sts_set = ev_q.evt ? (GPE_W'(1) << GPE_BIT) : '0;

    assert_plug_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        plug_ok |=> map_bits[$past(plug_idx)]);

    assert_unplug_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (unplug_ok && !(plug_ok && plug_idx == unplug_idx)) |=> !map_bits[$past(unplug_idx)]);

    assert_tie_plug_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (plug_ok && unplug_ok && plug_idx == unplug_idx) |=> map_bits[$past(plug_idx)]);

    assert_evt_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (plug_ok || unplug_ok) |=> (gpe_sts_set == (GPE_W'(1) << GPE_BIT)));

    assert_no_evt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(plug_ok || unplug_ok) |=> (gpe_sts_set == '0));
endmodule

// File: tb/cpu_presence_map_bench.sv
module cpu_presence_map_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N   = 256;
    localparam int IDW = 9;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   init_present;
    logic           plug_vld = 1'b0, unplug_vld = 1'b0;
    logic [IDW-1:0] plug_id = '0, unplug_id = '0;
    logic           win_req = 1'b0, win_we = 1'b0, win_byte = 1'b0;
    logic [4:0]     win_addr = '0;
    logic           rd_vld;
    logic [7:0]     rd_data;
    logic [7:0]     gpe_sts_set;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;
    bit ref_map [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_presence_map u_cpu_presence_map (
        .clk(clk), .rst_n(rst_n), .init_present(init_present),
        .plug_vld(plug_vld), .plug_id(plug_id),
        .unplug_vld(unplug_vld), .unplug_id(unplug_id),
        .win_req(win_req), .win_we(win_we), .win_byte(win_byte), .win_addr(win_addr),
        .rd_vld(rd_vld), .rd_data(rd_data), .gpe_sts_set(gpe_sts_set)
    );

    function automatic int ref_byte(int a);
        int v = 0;
        for (int j = 0; j < 8; j++) v |= (ref_map[8*a + j] ? 1 : 0) << j;
        return v;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One clock: drive at negedge, predict, step, compare at next negedge.
    task automatic cyc(string tag, bit pv, int pid, bit uv, int uid,
                       bit rq, bit we, bit by, int addr);
        int  e_rv, e_rd, e_ev;
        plug_vld = pv;   plug_id = IDW'(pid);
        unplug_vld = uv; unplug_id = IDW'(uid);
        win_req = rq; win_we = we; win_byte = by; win_addr = 5'(addr);
        e_rv = (rq && !we) ? 1 : 0;
        e_rd = (rq && !we && by) ? ref_byte(addr) : 0;
        e_ev = ((pv && pid < N) || (uv && uid < N)) ? 8'h04 : 8'h00;
        if (uv && uid < N) ref_map[uid] = 1'b0;
        if (pv && pid < N) ref_map[pid] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(tag, "rd_vld", int'(rd_vld), e_rv);
        check(tag, "rd_data", int'(rd_data), e_rd);
        check(tag, "gpe_sts_set", int'(gpe_sts_set), e_ev);
    endtask

    task automatic idle(string tag);
        cyc(tag, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic rd(string tag, int addr);
        cyc(tag, 0, 0, 0, 0, 1, 0, 1, addr);
    endtask

    task automatic sweep(string tag);
        for (int a = 0; a < N/8; a++) rd(tag, a);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            init_present[i] = (i % 3 == 0) || (i == 255);
            ref_map[i] = init_present[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle("R1");                       // reset state of outputs
        sweep("R1_R2");                   // init map and byte/bit order

        cyc("R3", 1, 1, 0, 0, 0, 0, 0, 0);
        cyc("R3", 1, 7, 0, 0, 0, 0, 0, 0);
        cyc("R3", 1, 254, 0, 0, 0, 0, 0, 0);
        cyc("R3", 0, 0, 1, 0, 0, 0, 0, 0);
        cyc("R3", 0, 0, 1, 255, 0, 0, 0, 0);
        rd("R3", 0); rd("R3", 31);

        cyc("R4", 1, 40, 1, 40, 0, 0, 0, 0);   // tie: plug wins
        cyc("R4", 1, 41, 1, 42, 0, 0, 0, 0);   // different: both apply
        rd("R4", 5);

        cyc("R6", 0, 0, 1, 3, 0, 0, 0, 0);     // clear bit 3 (in range)
        cyc("R6", 1, 256, 0, 0, 0, 0, 0, 0);   // alias of 0: dropped
        cyc("R6", 1, 259, 0, 0, 0, 0, 0, 0);   // alias of 3: dropped
        cyc("R6", 0, 0, 1, 262, 0, 0, 0, 0);   // alias of 6: dropped
        cyc("R6", 1, 511, 1, 300, 0, 0, 0, 0);
        rd("R6", 0);

        cyc("R7", 1, 16, 0, 0, 1, 0, 1, 2);    // read sees old byte
        cyc("R7", 0, 0, 1, 18, 1, 0, 1, 2);
        rd("R7", 2);
        cyc("R5", 1, 20, 0, 0, 0, 0, 0, 0);
        idle("R5");                             // pulse lasts one cycle

        for (int a = 0; a < N/8; a++) cyc("R8", 0, 0, 0, 0, 1, 1, a % 2, a);
        sweep("R8");

        cyc("R9", 0, 0, 0, 0, 1, 0, 0, 4);
        cyc("R9", 0, 0, 0, 0, 1, 0, 0, 31);
        idle("R10");

        for (int k = 0; k < 600; k++) begin
            cyc("R5_R7", 1'($urandom_range(0, 1)), int'($urandom_range(0, 300)),
                1'($urandom_range(0, 1)), int'($urandom_range(0, 300)),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0),
                1'($urandom_range(0, 7) != 0), int'($urandom_range(0, 31)));
        end
        sweep("R2");

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule